// File: doc/BRIEF.md
# Memory ECC Error Injection Unit

This unit sits between the ECC encoder and the DRAM interface on the write path of a memory controller. For every access it receives the decoded address (DIMM within its channel, rank, channel, bank, page, column), a write flag, and the check bits the encoder produced for a data word split into two halves. When injection is armed and a write matches the programmed address pattern, it inverts selected check bits before they leave for memory. A later read of that location then shows a correctable or uncorrectable error, so software can exercise its error-handling paths without faulty hardware.

Software programs the unit through a small register port. Each of the six address fields has its own match register. A set "any" bit makes that field match every value, and every field starts as "any" after reset. Further registers hold the ECC bit mask, the half-word section select, the injection type and the arm control. In one-shot mode the arm control drops after the first corrupted write. In repeat mode every matching write is corrupted until software disarms the unit.

Each half of the check word is ECC_W+1 bits wide: ECC bits [ECC_W-1:0] and a parity bit at [ECC_W]. The lower half sits at check-word bits [ECC_W:0] and the upper half directly above it.

Top module: `ecc_inject_unit`

## Requirements
- R1: After reset, each match register (addresses 0 to 5: DIMM, rank, channel, bank, page, column) reads 0x8000_0000, which is the "any" bit 31 set and a value of 0. The mask (6), section (7), type (8) and arm (9) registers read 0. inj_flag is 0 and chk_out is 0.
- R2: Every register reads back what was written, limited to its implemented bits. A match register keeps bit 31 and its field-width value bits. The mask keeps ECC_W bits, the section keeps 2 bits, the type keeps 3 bits, and arm reads as a single bit.
- R3: An armed write access is corrupted only if every match field whose "any" bit is clear equals the corresponding access field. A mismatch in any one such field leaves the check bits unchanged.
- R4: An access with acc_write low is never corrupted. Its check bits pass through unchanged and inj_flag stays 0.
- R5: With type bit 1 (ECC) set, an injection XORs the mask register into the ECC bits of each selected half.
- R6: Section value 1 selects the lower half, 2 the upper half and 3 both halves. Section 0 selects neither half: no injection takes place, and arm is left unchanged.
- R7: With type bit 2 (parity) set, an injection inverts the parity bit of each selected half, whatever the mask holds. If the type has neither bit 1 nor bit 2 set, no injection takes place.
- R8: With type bit 0 (repeat) clear, arm reads 0 after the first injection, and later matching writes pass unchanged.
- R9: With type bit 0 set, every matching write is corrupted while armed. Writing 0 to the arm register stops injection.
- R10: chk_out and inj_flag are registered. They reflect an access one clock after acc_valid is sampled high, and inj_flag is high for exactly that one cycle. In a cycle without acc_valid, chk_out holds its value and inj_flag is 0.
- R11: Writing any nonzero value to the arm register arms injection, and arm then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0..9) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write |
| acc_dimm | input | DIMM_W | DIMM index within the channel |
| acc_rank | input | RANK_W | Rank |
| acc_chan | input | CHAN_W | Channel |
| acc_bank | input | BANK_W | Bank |
| acc_page | input | PAGE_W | Page (row) address |
| acc_col | input | COL_W | Column address |
| chk_in | input | 2*(ECC_W+1) | Check bits from the encoder, two halves |
| chk_out | output | 2*(ECC_W+1) | Check bits toward memory, possibly corrupted |
| inj_flag | output | 1 | One-cycle pulse with a corrupted chk_out |

## Verification
On every cycle, the assertions check the following:
- a read passes its check bits through unaltered;
- an idle cycle holds the output and never raises the flag;
- the flag only follows an armed write;
- section 0 never injects;
- arm drops after a one-shot injection and stays set after a repeat injection.

The values of the flipped bits depend on the mask, section and type together, so only the bench's scenarios can show them. The same holds for address matching across wildcard and non-wildcard fields, register readback and the reset contents. The bench covers these with a vector table in repeat mode and with directed sequences for the one-shot, parity-only, single-half and disarm cases.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;
  localparam int NFLD   = 6;

  localparam logic [ADDR_W-1:0] A_DIMM = 4'd0;
  localparam logic [ADDR_W-1:0] A_RANK = 4'd1;
  localparam logic [ADDR_W-1:0] A_CHAN = 4'd2;
  localparam logic [ADDR_W-1:0] A_BANK = 4'd3;
  localparam logic [ADDR_W-1:0] A_PAGE = 4'd4;
  localparam logic [ADDR_W-1:0] A_COL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd6;
  localparam logic [ADDR_W-1:0] A_SECT = 4'd7;
  localparam logic [ADDR_W-1:0] A_TYPE = 4'd8;
  localparam logic [ADDR_W-1:0] A_ARM  = 4'd9;

  // injection type bit positions
  localparam int TY_REPEAT = 0;
  localparam int TY_ECC    = 1;
  localparam int TY_PAR    = 2;

  // wildcard vector index per field
  localparam int F_DIMM = 0;
  localparam int F_RANK = 1;
  localparam int F_CHAN = 2;
  localparam int F_BANK = 3;
  localparam int F_PAGE = 4;
  localparam int F_COL  = 5;
endpackage

// File: rtl/ecc_inj_rst_sync.sv
module ecc_inj_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
  import ecc_inj_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int ECC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              inj_hit,
  output logic [NFLD-1:0]   wild,
  output logic [DIMM_W-1:0] m_dimm,
  output logic [RANK_W-1:0] m_rank,
  output logic [CHAN_W-1:0] m_chan,
  output logic [BANK_W-1:0] m_bank,
  output logic [PAGE_W-1:0] m_page,
  output logic [COL_W-1:0]  m_col,
  output logic [ECC_W-1:0]  mask,
  output logic [1:0]        sect,
  output logic [2:0]        itype,
  output logic              armed
);
  localparam int WB = REG_W - 1;

  logic [NFLD-1:0]   wild_q, wild_d;
  logic [DIMM_W-1:0] dimm_q, dimm_d;
  logic [RANK_W-1:0] rank_q, rank_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [COL_W-1:0]  col_q,  col_d;
  logic [ECC_W-1:0]  mask_q, mask_d;
  logic [1:0]        sect_q, sect_d;
  logic [2:0]        type_q, type_d;
  logic              arm_q,  arm_d;

  always_comb begin
    wild_d = wild_q;
    dimm_d = dimm_q;
    rank_d = rank_q;
    chan_d = chan_q;
    bank_d = bank_q;
    page_d = page_q;
    col_d  = col_q;
    mask_d = mask_q;
    sect_d = sect_q;
    type_d = type_q;
    arm_d  = arm_q;
    // one-shot disarm; a register write in the same cycle takes priority
    if (inj_hit && !type_q[TY_REPEAT]) arm_d = 1'b0;
    if (we) begin
      case (addr)
        A_DIMM: begin wild_d[F_DIMM] = wdata[WB]; dimm_d = wdata[DIMM_W-1:0]; end
        A_RANK: begin wild_d[F_RANK] = wdata[WB]; rank_d = wdata[RANK_W-1:0]; end
        A_CHAN: begin wild_d[F_CHAN] = wdata[WB]; chan_d = wdata[CHAN_W-1:0]; end
        A_BANK: begin wild_d[F_BANK] = wdata[WB]; bank_d = wdata[BANK_W-1:0]; end
        A_PAGE: begin wild_d[F_PAGE] = wdata[WB]; page_d = wdata[PAGE_W-1:0]; end
        A_COL:  begin wild_d[F_COL]  = wdata[WB]; col_d  = wdata[COL_W-1:0];  end
        A_MASK: mask_d = wdata[ECC_W-1:0];
        A_SECT: sect_d = wdata[1:0];
        A_TYPE: type_d = wdata[2:0];
        A_ARM:  arm_d  = |wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wild_q <= '1;
      dimm_q <= '0;
      rank_q <= '0;
      chan_q <= '0;
      bank_q <= '0;
      page_q <= '0;
      col_q  <= '0;
      mask_q <= '0;
      sect_q <= '0;
      type_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      wild_q <= wild_d;
      dimm_q <= dimm_d;
      rank_q <= rank_d;
      chan_q <= chan_d;
      bank_q <= bank_d;
      page_q <= page_d;
      col_q  <= col_d;
      mask_q <= mask_d;
      sect_q <= sect_d;
      type_q <= type_d;
      arm_q  <= arm_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIMM: begin rdata[WB] = wild_q[F_DIMM]; rdata[DIMM_W-1:0] = dimm_q; end
      A_RANK: begin rdata[WB] = wild_q[F_RANK]; rdata[RANK_W-1:0] = rank_q; end
      A_CHAN: begin rdata[WB] = wild_q[F_CHAN]; rdata[CHAN_W-1:0] = chan_q; end
      A_BANK: begin rdata[WB] = wild_q[F_BANK]; rdata[BANK_W-1:0] = bank_q; end
      A_PAGE: begin rdata[WB] = wild_q[F_PAGE]; rdata[PAGE_W-1:0] = page_q; end
      A_COL:  begin rdata[WB] = wild_q[F_COL];  rdata[COL_W-1:0]  = col_q;  end
      A_MASK: rdata[ECC_W-1:0] = mask_q;
      A_SECT: rdata[1:0] = sect_q;
      A_TYPE: rdata[2:0] = type_q;
      A_ARM:  rdata[0] = arm_q;
      default: ;
    endcase
  end

  assign wild   = wild_q;
  assign m_dimm = dimm_q;
  assign m_rank = rank_q;
  assign m_chan = chan_q;
  assign m_bank = bank_q;
  assign m_page = page_q;
  assign m_col  = col_q;
  assign mask   = mask_q;
  assign sect   = sect_q;
  assign itype  = type_q;
  assign armed  = arm_q;
endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_fld #(
  parameter int W = 2
) (
  input  logic         any,
  input  logic [W-1:0] want,
  input  logic [W-1:0] got,
  output logic         hit
);
  assign hit = any | (want == got);
endmodule

module ecc_inj_match
  import ecc_inj_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10
) (
  input  logic [NFLD-1:0]   wild,
  input  logic [DIMM_W-1:0] m_dimm,
  input  logic [RANK_W-1:0] m_rank,
  input  logic [CHAN_W-1:0] m_chan,
  input  logic [BANK_W-1:0] m_bank,
  input  logic [PAGE_W-1:0] m_page,
  input  logic [COL_W-1:0]  m_col,
  input  logic [DIMM_W-1:0] a_dimm,
  input  logic [RANK_W-1:0] a_rank,
  input  logic [CHAN_W-1:0] a_chan,
  input  logic [BANK_W-1:0] a_bank,
  input  logic [PAGE_W-1:0] a_page,
  input  logic [COL_W-1:0]  a_col,
  output logic              match
);
  logic [NFLD-1:0] fhit;

  ecc_inj_fld #(.W(DIMM_W)) u_dimm (.any(wild[F_DIMM]), .want(m_dimm), .got(a_dimm), .hit(fhit[F_DIMM]));
  ecc_inj_fld #(.W(RANK_W)) u_rank (.any(wild[F_RANK]), .want(m_rank), .got(a_rank), .hit(fhit[F_RANK]));
  ecc_inj_fld #(.W(CHAN_W)) u_chan (.any(wild[F_CHAN]), .want(m_chan), .got(a_chan), .hit(fhit[F_CHAN]));
  ecc_inj_fld #(.W(BANK_W)) u_bank (.any(wild[F_BANK]), .want(m_bank), .got(a_bank), .hit(fhit[F_BANK]));
  ecc_inj_fld #(.W(PAGE_W)) u_page (.any(wild[F_PAGE]), .want(m_page), .got(a_page), .hit(fhit[F_PAGE]));
  ecc_inj_fld #(.W(COL_W))  u_col  (.any(wild[F_COL]),  .want(m_col),  .got(a_col),  .hit(fhit[F_COL]));

  assign match = &fhit;
endmodule

// File: rtl/ecc_inj_flip.sv
module ecc_inj_flip
  import ecc_inj_pkg::*;
#(
  parameter int ECC_W = 8
) (
  input  logic [ECC_W-1:0]       mask,
  input  logic [1:0]             sect,
  input  logic [2:0]             itype,
  output logic [2*(ECC_W+1)-1:0] flip,
  output logic                   effective
);
  localparam int HALF_W = ECC_W + 1;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign flip[h*HALF_W +: ECC_W] = (sect[h] && itype[TY_ECC]) ? mask : '0;
    assign flip[h*HALF_W + ECC_W]  = sect[h] && itype[TY_PAR];
  end

  assign effective = (|sect) && (itype[TY_ECC] || itype[TY_PAR]);
endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
  import ecc_inj_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int ECC_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [3:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [DIMM_W-1:0]        acc_dimm,
  input  logic [RANK_W-1:0]        acc_rank,
  input  logic [CHAN_W-1:0]        acc_chan,
  input  logic [BANK_W-1:0]        acc_bank,
  input  logic [PAGE_W-1:0]        acc_page,
  input  logic [COL_W-1:0]         acc_col,
  input  logic [2*(ECC_W+1)-1:0]   chk_in,
  output logic [2*(ECC_W+1)-1:0]   chk_out,
  output logic                     inj_flag
);
  localparam int CHK_W = 2 * (ECC_W + 1);

  logic              rst_n_s;
  logic [NFLD-1:0]   wild;
  logic [DIMM_W-1:0] m_dimm;
  logic [RANK_W-1:0] m_rank;
  logic [CHAN_W-1:0] m_chan;
  logic [BANK_W-1:0] m_bank;
  logic [PAGE_W-1:0] m_page;
  logic [COL_W-1:0]  m_col;
  logic [ECC_W-1:0]  mask;
  logic [1:0]        sect;
  logic [2:0]        itype;
  logic              armed;
  logic              addr_match;
  logic              effective;
  logic [CHK_W-1:0]  flip;
  logic              hit;
  logic [CHK_W-1:0]  chk_q, chk_d;
  logic              flag_q, flag_d;

  ecc_inj_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  ecc_inj_regs #(
    .DIMM_W(DIMM_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W), .BANK_W(BANK_W),
    .PAGE_W(PAGE_W), .COL_W(COL_W), .ECC_W(ECC_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .inj_hit(hit), .wild(wild), .m_dimm(m_dimm), .m_rank(m_rank),
    .m_chan(m_chan), .m_bank(m_bank), .m_page(m_page), .m_col(m_col), .mask(mask),
    .sect(sect), .itype(itype), .armed(armed)
  );

  ecc_inj_match #(
    .DIMM_W(DIMM_W), .RANK_W(RANK_W), .CHAN_W(CHAN_W), .BANK_W(BANK_W),
    .PAGE_W(PAGE_W), .COL_W(COL_W)
  ) u_match (
    .wild(wild), .m_dimm(m_dimm), .m_rank(m_rank), .m_chan(m_chan), .m_bank(m_bank),
    .m_page(m_page), .m_col(m_col), .a_dimm(acc_dimm), .a_rank(acc_rank),
    .a_chan(acc_chan), .a_bank(acc_bank), .a_page(acc_page), .a_col(acc_col),
    .match(addr_match)
  );

  ecc_inj_flip #(.ECC_W(ECC_W)) u_flip (
    .mask(mask), .sect(sect), .itype(itype), .flip(flip), .effective(effective)
  );

  assign hit = armed && acc_valid && acc_write && addr_match && effective;

  always_comb begin
    chk_d  = chk_q;
    flag_d = hit;
    if (acc_valid) chk_d = chk_in ^ (hit ? flip : '0);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      chk_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      chk_q  <= chk_d;
      flag_q <= flag_d;
    end
  end

  assign chk_out  = chk_q;
  assign inj_flag = flag_q;
endmodule

// File: rtl/ecc_inj_chk.sv
module ecc_inj_chk
  import ecc_inj_pkg::*;
#(
  parameter int ECC_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [3:0]             reg_addr,
  input logic                   acc_valid,
  input logic                   acc_write,
  input logic [2*(ECC_W+1)-1:0] chk_in,
  input logic [2*(ECC_W+1)-1:0] chk_out,
  input logic                   inj_flag,
  input logic                   armed,
  input logic [1:0]             sect,
  input logic [2:0]             itype
);
  logic arm_wr;
  assign arm_wr = reg_we && (reg_addr == A_ARM);

  a_r10_flag_after_armed_write: assert property (@(posedge clk) disable iff (!rst_n)
    inj_flag |-> $past(acc_valid && acc_write && armed));

  a_r4_read_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> (chk_out == $past(chk_in)) && !inj_flag);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(chk_out) && !inj_flag);

  a_r6_no_section_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && sect == 2'b00) |=> !inj_flag);

  a_r8_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_flag && !$past(itype[TY_REPEAT]) && !$past(arm_wr)) |-> !armed);

  a_r9_repeat_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_flag && $past(itype[TY_REPEAT]) && !$past(arm_wr)) |-> armed);
endmodule

bind ecc_inject_unit ecc_inj_chk #(.ECC_W(ECC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .acc_valid(acc_valid), .acc_write(acc_write), .chk_in(chk_in), .chk_out(chk_out),
  .inj_flag(inj_flag), .armed(armed), .sect(sect), .itype(itype)
);

// File: tb/ecc_inject_unit_bench.sv
`timescale 1ns/1ps
module ecc_inject_unit_bench;
  localparam int ECC_W = 8;
  localparam int CHK_W = 2 * (ECC_W + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic acc_valid, acc_write;
  logic [1:0] acc_dimm, acc_rank, acc_chan;
  logic [2:0] acc_bank;
  logic [15:0] acc_page;
  logic [9:0] acc_col;
  logic [CHK_W-1:0] chk_in, chk_out;
  logic inj_flag;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  ecc_inject_unit u_ecc_inject_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_dimm(acc_dimm), .acc_rank(acc_rank),
    .acc_chan(acc_chan), .acc_bank(acc_bank), .acc_page(acc_page), .acc_col(acc_col),
    .chk_in(chk_in), .chk_out(chk_out), .inj_flag(inj_flag)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  chan;
    logic [2:0]  bank;
    logic [17:0] chk;
    logic        hit;
  } vec_t;

  // config for the table: chan=2, bank=5, other fields any; mask 0x41, both halves, repeat+ECC+parity
  localparam vec_t VECS [0:7] = '{
    '{1'b1, 2'd2, 3'd5, 18'h00000, 1'b1},
    '{1'b1, 2'd2, 3'd5, 18'h3FFFF, 1'b1},
    '{1'b1, 2'd1, 3'd5, 18'h0F0F0, 1'b0},
    '{1'b1, 2'd2, 3'd4, 18'h00FFF, 1'b0},
    '{1'b0, 2'd2, 3'd5, 18'h1234A, 1'b0},
    '{1'b1, 2'd2, 3'd5, 18'h12345, 1'b1},
    '{1'b1, 2'd3, 3'd5, 18'h2AAAA, 1'b0},
    '{1'b1, 2'd2, 3'd5, 18'h2AAAA, 1'b1}
  };

  function automatic logic [CHK_W-1:0] exp_flip(input logic [1:0] s, input logic [2:0] t,
                                                input logic [ECC_W-1:0] m);
    logic [CHK_W-1:0] f;
    f = '0;
    for (int h = 0; h < 2; h++) begin
      if (s[h] && t[1]) f[h*(ECC_W+1) +: ECC_W] = m;
      if (s[h] && t[2]) f[h*(ECC_W+1) + ECC_W] = 1'b1;
    end
    return f;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // one access; returns after the result is registered (sampled at next negedge)
  task automatic access(input logic wr, input logic [1:0] dimm, input logic [1:0] rank,
                        input logic [1:0] chan, input logic [2:0] bank,
                        input logic [15:0] page, input logic [9:0] col,
                        input logic [CHK_W-1:0] c);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_dimm = dimm; acc_rank = rank;
    acc_chan = chan; acc_bank = bank; acc_page = page; acc_col = col; chk_in = c;
    @(negedge clk);
    acc_valid = 1'b0;
    chk_in = ~c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [CHK_W-1:0] f;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_dimm = '0; acc_rank = '0; acc_chan = '0;
    acc_bank = '0; acc_page = '0; acc_col = '0; chk_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset contents
    for (int a = 0; a < 6; a++) begin
      rd_reg(a[3:0], rd);
      check($sformatf("R1 match reg %0d reset", a), rd, 32'h8000_0000);
    end
    for (int a = 6; a < 10; a++) begin
      rd_reg(a[3:0], rd);
      check($sformatf("R1 reg %0d reset", a), rd, 32'h0);
    end
    check("R1 flag reset", {31'b0, inj_flag}, 32'h0);
    check("R1 chk_out reset", {14'b0, chk_out}, 32'h0);

    // R2 readback with width limits
    wr_reg(4'd0, 32'h0000_0003); rd_reg(4'd0, rd); check("R2 dimm readback", rd, 32'h0000_0003);
    wr_reg(4'd4, 32'hFFFF_ABCD); rd_reg(4'd4, rd); check("R2 page readback", rd, 32'h8000_ABCD);
    wr_reg(4'd6, 32'h0000_0FFF); rd_reg(4'd6, rd); check("R2 mask readback", rd, 32'h0000_00FF);
    wr_reg(4'd7, 32'h0000_0007); rd_reg(4'd7, rd); check("R2 sect readback", rd, 32'h0000_0003);
    wr_reg(4'd8, 32'h0000_000F); rd_reg(4'd8, rd); check("R2 type readback", rd, 32'h0000_0007);
    wr_reg(4'd0, 32'h8000_0000);
    wr_reg(4'd4, 32'h8000_0000);

    // table: repeat mode, R3 R4 R5 R9
    wr_reg(4'd2, 32'h0000_0002);
    wr_reg(4'd3, 32'h0000_0005);
    wr_reg(4'd6, 32'h0000_0041);
    wr_reg(4'd7, 32'h0000_0003);
    wr_reg(4'd8, 32'h0000_0007);
    wr_reg(4'd9, 32'h0000_0001);
    f = exp_flip(2'd3, 3'd7, 8'h41);
    for (int i = 0; i < 8; i++) begin
      access(VECS[i].wr, i[1:0], ~i[1:0], VECS[i].chan, VECS[i].bank, 16'(i * 977),
             10'(i * 37), VECS[i].chk);
      check($sformatf("R3 R5 vec %0d chk_out", i), {14'b0, chk_out},
            {14'b0, VECS[i].chk ^ (VECS[i].hit ? f : '0)});
      check($sformatf("R3 R4 vec %0d flag", i), {31'b0, inj_flag}, {31'b0, VECS[i].hit});
    end
    rd_reg(4'd9, rd); check("R9 still armed after repeats", rd, 32'h1);

    // R10 idle cycle holds output, flag drops
    @(negedge clk);
    check("R10 idle hold chk_out", {14'b0, chk_out}, {14'b0, VECS[7].chk ^ f});
    check("R10 idle flag low", {31'b0, inj_flag}, 32'h0);

    // R9 disarm stops injection
    wr_reg(4'd9, 32'h0);
    access(1'b1, 2'd0, 2'd0, 2'd2, 3'd5, 16'd0, 10'd0, 18'h00000);
    check("R9 disarmed chk_out", {14'b0, chk_out}, 32'h0);
    check("R9 disarmed flag", {31'b0, inj_flag}, 32'h0);

    // R8 R11 one-shot, ECC only, lower half
    wr_reg(4'd6, 32'h0000_000F);
    wr_reg(4'd7, 32'h0000_0001);
    wr_reg(4'd8, 32'h0000_0002);
    wr_reg(4'd9, 32'h0000_0080);
    rd_reg(4'd9, rd); check("R11 nonzero arms", rd, 32'h1);
    access(1'b1, 2'd1, 2'd1, 2'd2, 3'd5, 16'd7, 10'd9, 18'h00000);
    check("R5 R6 lower-half ECC flip", {14'b0, chk_out}, 32'h0000_000F);
    check("R8 first write flagged", {31'b0, inj_flag}, 32'h1);
    rd_reg(4'd9, rd); check("R8 arm cleared", rd, 32'h0);
    access(1'b1, 2'd1, 2'd1, 2'd2, 3'd5, 16'd7, 10'd9, 18'h00000);
    check("R8 second write unchanged", {14'b0, chk_out}, 32'h0);
    check("R8 second write no flag", {31'b0, inj_flag}, 32'h0);

    // R7 R6 parity only, upper half, mask ignored
    wr_reg(4'd6, 32'h0000_00FF);
    wr_reg(4'd7, 32'h0000_0002);
    wr_reg(4'd8, 32'h0000_0005);
    wr_reg(4'd9, 32'h0000_0001);
    access(1'b1, 2'd0, 2'd0, 2'd2, 3'd5, 16'd0, 10'd0, 18'h00000);
    check("R7 upper parity only", {14'b0, chk_out}, 32'h0002_0000);

    // R7 type with neither ECC nor parity: no injection
    wr_reg(4'd7, 32'h0000_0003);
    wr_reg(4'd8, 32'h0000_0001);
    access(1'b1, 2'd0, 2'd0, 2'd2, 3'd5, 16'd0, 10'd0, 18'h00055);
    check("R7 no kind selected chk_out", {14'b0, chk_out}, 32'h0000_0055);
    check("R7 no kind selected flag", {31'b0, inj_flag}, 32'h0);

    // R6 section 0: no injection, arm kept
    wr_reg(4'd7, 32'h0000_0000);
    wr_reg(4'd8, 32'h0000_0006);
    access(1'b1, 2'd0, 2'd0, 2'd2, 3'd5, 16'd0, 10'd0, 18'h00033);
    check("R6 section0 chk_out", {14'b0, chk_out}, 32'h0000_0033);
    check("R6 section0 flag", {31'b0, inj_flag}, 32'h0);
    rd_reg(4'd9, rd); check("R6 section0 keeps arm", rd, 32'h1);

    // R3 all fields specified, one mismatch at a time
    wr_reg(4'd0, 32'h0000_0001);
    wr_reg(4'd1, 32'h0000_0002);
    wr_reg(4'd2, 32'h0000_0003);
    wr_reg(4'd3, 32'h0000_0006);
    wr_reg(4'd4, 32'h0000_1234);
    wr_reg(4'd5, 32'h0000_0155);
    wr_reg(4'd6, 32'h0000_0080);
    wr_reg(4'd7, 32'h0000_0003);
    wr_reg(4'd8, 32'h0000_0003);
    access(1'b1, 2'd1, 2'd2, 2'd3, 3'd6, 16'h1234, 10'h155, 18'h00000);
    check("R3 R5 full match both halves", {14'b0, chk_out}, 32'h0001_0080);
    access(1'b1, 2'd1, 2'd1, 2'd3, 3'd6, 16'h1234, 10'h155, 18'h00000);
    check("R3 rank mismatch", {14'b0, chk_out}, 32'h0);
    access(1'b1, 2'd1, 2'd2, 2'd3, 3'd6, 16'h1235, 10'h155, 18'h00000);
    check("R3 page mismatch", {14'b0, chk_out}, 32'h0);
    access(1'b1, 2'd1, 2'd2, 2'd3, 3'd6, 16'h1234, 10'h154, 18'h00000);
    check("R3 col mismatch flag", {31'b0, inj_flag}, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule